// File: doc/BRIEF.md
# Retained Register Domain with Output Clamps

This block models a small bank of registers that sits in a switchable power domain. Each register can be written through a simple load port while the domain supply is good. A parameter picks which registers own a shadow copy on the always-on supply. One retention control line moves data between the working registers and those shadows. A parameter selects how that line is read. In level style, high copies the working registers into the shadows, and low brings them back after a power loss. In edge style, a rising edge copies and a falling edge brings back.

While the supply-good input is low, the working registers are taken to hold garbage. The block raises a corruption flag instead of producing unknown values. Only the shadows keep their contents. On a restore, retained registers take their shadow value and all others return to zero. An isolation input replaces every output group with a fixed all-zeros or all-ones word. The polarity of each group is set per group by a parameter mask.

Top module: `pwr_ret_domain`

## Requirements
- R1: Driving `rst_n` low clears at once all working registers, all shadows, the corruption flag and the stored copy of the control line. Logic starts running two rising clock edges after `rst_n` goes high again.
- R2: When `wr_en` and `pwr_good` are high at a clock edge, register `wr_idx` takes `wr_data`. When `pwr_good` is low, the write is dropped and the register keeps its previous content.
- R3: While `iso_en` is high, output group i (bits i*DATA_W and up) shows all ones if bit i of `CLAMP_ONES` is 1 and all zeros otherwise, with no clock delay. While `iso_en` is low, it shows register i.
- R4: Level style: at every edge where `ret_ctl` is high, `pwr_good` is high and `corrupt` is low, every retained shadow copies the value its working register held before that edge.
- R5: Level style: at an edge where `ret_ctl` is low, `pwr_good` is high and `corrupt` is high, a restore takes place.
- R6: Edge style: a save takes place at an edge where `ret_ctl` is high but was low at the previous edge, provided `pwr_good` is high and `corrupt` is low.
- R7: Edge style: a restore takes place at an edge where `ret_ctl` is low but was high at the previous edge, provided `pwr_good` is high. This holds whether or not `corrupt` is set.
- R8: On a restore, each retained register loads its shadow, each non-retained register loads zero, and `corrupt` clears. A restore overrides a write in the same cycle.
- R9: `corrupt` goes high after any edge with `pwr_good` low. It then stays high until a restore or a reset.
- R10: A save request is dropped while `pwr_good` is low or `corrupt` is high, so corrupt contents never reach a shadow.
- R11: A shadow keeps its value for as long as no save takes place, whatever happens to the supply or the working registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the working and always-on registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Load strobe for one working register |
| wr_idx | input | IDX_W | Index of the register to load |
| wr_data | input | DATA_W | Value to load |
| ret_ctl | input | 1 | Retention control line (level or edge style) |
| iso_en | input | 1 | Clamps all output groups when high |
| pwr_good | input | 1 | Domain supply is up when high |
| data_out | output | NUM_REGS*DATA_W | Isolated register contents, register 0 in the low bits |
| corrupt | output | 1 | Working register contents are invalid |

## Verification
Two clashes can fall in the same cycle: a write with a save, and a write with a restore. The bench raises `ret_ctl` in the same cycle as a write to a retained register. Level style must then hold the new value in the shadow one cycle later. Edge style must keep only the value from before the write, and a later edge-style restore shows which value the shadow captured. The bench also writes in the cycle where the falling edge restores the edge-style instance. The restored value must win there, while the level-style instance, which has no restore due, keeps the written value.

// File: rtl/pwr_ret_pkg.sv
package pwr_ret_pkg;

  // How the retention control line is interpreted
  typedef enum logic {
    RET_LEVEL = 1'b0,
    RET_EDGE  = 1'b1
  } ret_mode_e;

endpackage

// File: rtl/pwr_ret_ctl.sv
// Turns the retention control line into one-cycle save / restore requests.
module pwr_ret_ctl
  import pwr_ret_pkg::*;
#(
  parameter ret_mode_e MODE = RET_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_ctl,
  input  logic pwr_good,
  input  logic corrupt,
  output logic save_req,
  output logic restore_req
);

  // Always-on copy of the control line, used to find edges
  logic ctl_q;
  logic ctl_d;
  logic rise;
  logic fall;

  always_comb begin
    ctl_d = ret_ctl;
    rise  = ret_ctl & ~ctl_q;
    fall  = ~ret_ctl & ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    if (MODE == RET_EDGE) begin
      save_req    = rise & pwr_good & ~corrupt;
      restore_req = fall & pwr_good;
    end else begin
      save_req    = ret_ctl & pwr_good & ~corrupt;
      restore_req = ~ret_ctl & pwr_good & corrupt;
    end
  end

endmodule

// File: rtl/pwr_ret_slice.sv
// One working register with an optional always-on shadow.
module pwr_ret_slice #(
  parameter int DATA_W   = 8,
  parameter bit RETAINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              save_req,
  input  logic              restore_req,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] main_q;
  logic [DATA_W-1:0] main_d;
  logic [DATA_W-1:0] restore_val;

  generate
    if (RETAINED) begin : g_shadow
      logic [DATA_W-1:0] shadow_q;
      logic [DATA_W-1:0] shadow_d;

      always_comb begin
        shadow_d = shadow_q;
        if (save_req) begin
          shadow_d = main_q;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q <= '0;
        end else begin
          shadow_q <= shadow_d;
        end
      end

      assign restore_val = shadow_q;
    end else begin : g_plain
      logic unused_save;
      assign unused_save = save_req;
      assign restore_val = '0;
    end
  endgenerate

  always_comb begin
    main_d = main_q;
    if (restore_req) begin
      main_d = restore_val;
    end else if (load_en) begin
      main_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
    end else begin
      main_q <= main_d;
    end
  end

  assign q = main_q;

endmodule

// File: rtl/pwr_ret_iso.sv
// Per-group output clamps.
module pwr_ret_iso #(
  parameter int              NUM_REGS   = 4,
  parameter int              DATA_W     = 8,
  parameter logic [NUM_REGS-1:0] CLAMP_ONES = '0
) (
  input  logic                       iso_en,
  input  logic [NUM_REGS*DATA_W-1:0] din,
  output logic [NUM_REGS*DATA_W-1:0] dout
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_grp
    localparam logic [DATA_W-1:0] CLAMP_WORD = {DATA_W{CLAMP_ONES[g]}};
    assign dout[g*DATA_W +: DATA_W] = iso_en ? CLAMP_WORD : din[g*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/pwr_ret_domain.sv
// Top: switchable register bank with shadows, corruption flag and clamps.
module pwr_ret_domain
  import pwr_ret_pkg::*;
#(
  parameter int                  NUM_REGS   = 4,
  parameter int                  DATA_W     = 8,
  parameter logic [NUM_REGS-1:0] RET_MASK   = 4'b0101,
  parameter logic [NUM_REGS-1:0] CLAMP_ONES = 4'b1010,
  parameter ret_mode_e           RET_MODE   = RET_LEVEL,
  localparam int                 IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       ret_ctl,
  input  logic                       iso_en,
  input  logic                       pwr_good,
  output logic [NUM_REGS*DATA_W-1:0] data_out,
  output logic                       corrupt
);

  localparam int BUS_W = NUM_REGS * DATA_W;

  // Reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  // Retention requests
  logic save_req;
  logic restore_req;

  pwr_ret_ctl #(
    .MODE (RET_MODE)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ret_ctl     (ret_ctl),
    .pwr_good    (pwr_good),
    .corrupt     (corrupt),
    .save_req    (save_req),
    .restore_req (restore_req)
  );

  // Corruption flag
  logic corrupt_q;
  logic corrupt_d;

  always_comb begin
    corrupt_d = corrupt_q;
    if (!pwr_good) begin
      corrupt_d = 1'b1;
    end else if (restore_req) begin
      corrupt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      corrupt_q <= 1'b0;
    end else begin
      corrupt_q <= corrupt_d;
    end
  end

  assign corrupt = corrupt_q;

  // Register bank
  logic [NUM_REGS-1:0] load_hit;
  logic [BUS_W-1:0]    bank_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign load_hit[i] = wr_en & pwr_good & (wr_idx == IDX_W'(i));

    pwr_ret_slice #(
      .DATA_W   (DATA_W),
      .RETAINED (RET_MASK[i])
    ) u_slice (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .load_en     (load_hit[i]),
      .load_data   (wr_data),
      .save_req    (save_req),
      .restore_req (restore_req),
      .q           (bank_q[i*DATA_W +: DATA_W])
    );
  end

  // Output clamps
  pwr_ret_iso #(
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W),
    .CLAMP_ONES (CLAMP_ONES)
  ) u_iso (
    .iso_en (iso_en),
    .din    (bank_q),
    .dout   (data_out)
  );

endmodule

// File: rtl/pwr_ret_domain_chk.sv
// Property checker attached to every pwr_ret_domain instance.
module pwr_ret_domain_chk #(
  parameter int                  NUM_REGS   = 4,
  parameter int                  DATA_W     = 8,
  parameter logic [NUM_REGS-1:0] CLAMP_ONES = '0,
  parameter int                  IDX_W      = 2
) (
  input logic                       clk,
  input logic                       rst_ok,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       iso_en,
  input logic                       pwr_good,
  input logic [NUM_REGS*DATA_W-1:0] data_out,
  input logic                       corrupt,
  input logic                       save_req,
  input logic                       restore_req
);

  logic [NUM_REGS*DATA_W-1:0] clamp_pat;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pat
    assign clamp_pat[g*DATA_W +: DATA_W] = {DATA_W{CLAMP_ONES[g]}};
  end

  // Remember the last accepted write
  logic              wr_seen_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic [DATA_W-1:0] wr_dat_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      wr_seen_q <= 1'b0;
      wr_idx_q  <= '0;
      wr_dat_q  <= '0;
    end else begin
      wr_seen_q <= wr_en & pwr_good & ~restore_req;
      wr_idx_q  <= wr_idx;
      wr_dat_q  <= wr_data;
    end
  end

  // R3
  iso_clamp_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    iso_en |-> data_out == clamp_pat);

  // R2
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_seen_q && !iso_en) |-> data_out[wr_idx_q*DATA_W +: DATA_W] == wr_dat_q);

  // R9
  corrupt_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !pwr_good |=> corrupt);

  // R9
  corrupt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (corrupt && !restore_req) |=> corrupt);

  // R8
  restore_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (restore_req && pwr_good) |=> !corrupt);

  // R10
  no_save_off_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!pwr_good || corrupt) |-> !save_req);

  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(save_req && restore_req));

endmodule

bind pwr_ret_domain pwr_ret_domain_chk #(
  .NUM_REGS   (NUM_REGS),
  .DATA_W     (DATA_W),
  .CLAMP_ONES (CLAMP_ONES),
  .IDX_W      (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .iso_en      (iso_en),
  .pwr_good    (pwr_good),
  .data_out    (data_out),
  .corrupt     (corrupt),
  .save_req    (save_req),
  .restore_req (restore_req)
);

// File: tb/pwr_ret_domain_test.sv
module pwr_ret_domain_test;
  import pwr_ret_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_idx;
  logic [7:0]  wr_data;
  logic        ret_ctl;
  logic        iso_en;
  logic        pwr_good;
  logic [31:0] out_l;
  logic [31:0] out_e;
  logic        cor_l;
  logic        cor_e;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  // Registers 0 and 2 retained; groups 1 and 3 clamp to ones
  pwr_ret_domain #(
    .NUM_REGS (4), .DATA_W (8), .RET_MASK (4'b0101),
    .CLAMP_ONES (4'b1010), .RET_MODE (RET_LEVEL)
  ) uut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
    .wr_data (wr_data), .ret_ctl (ret_ctl), .iso_en (iso_en),
    .pwr_good (pwr_good), .data_out (out_l), .corrupt (cor_l)
  );

  pwr_ret_domain #(
    .NUM_REGS (4), .DATA_W (8), .RET_MASK (4'b0101),
    .CLAMP_ONES (4'b1010), .RET_MODE (RET_EDGE)
  ) uut_edge (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
    .wr_data (wr_data), .ret_ctl (ret_ctl), .iso_en (iso_en),
    .pwr_good (pwr_good), .data_out (out_e), .corrupt (cor_e)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic w, input logic [1:0] ix, input logic [7:0] d,
                      input logic r, input logic iso, input logic pg,
                      input logic [31:0] exp_l, input logic [31:0] exp_e,
                      input logic ecl, input logic ece, input string tag);
    wr_en = w; wr_idx = ix; wr_data = d;
    ret_ctl = r; iso_en = iso; pwr_good = pg;
    @(negedge clk);
    check(tag, "level data_out", out_l, exp_l);
    check(tag, "edge data_out", out_e, exp_e);
    check(tag, "level corrupt", {31'd0, cor_l}, {31'd0, ecl});
    check(tag, "edge corrupt", {31'd0, cor_e}, {31'd0, ece});
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  idx;
    logic [7:0]  dat;
    logic        ret;
    logic        iso;
    logic        pg;
    logic [31:0] exp;
    logic        cl;
    logic        ce;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 8'h11, 1'b0, 1'b0, 1'b1, 32'h00000011, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 2'd1, 8'h22, 1'b0, 1'b0, 1'b1, 32'h00002211, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 2'd2, 8'h33, 1'b0, 1'b0, 1'b1, 32'h00332211, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 2'd3, 8'h44, 1'b0, 1'b0, 1'b1, 32'h44332211, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 1'b0, 4'd3},  // R3 isolate
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 1'b0, 4'd4},  // R4 / R6 save
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 32'hFF00FF00, 1'b1, 1'b1, 4'd9},  // R9 power off
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 32'hFF00FF00, 1'b1, 1'b1, 4'd9},  // R9
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 32'hFF00FF00, 1'b1, 1'b1, 4'd9},  // R9 power on, no restore yet
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 1'b0, 4'd5},  // R5 / R7 restore
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h00330011, 1'b0, 1'b0, 4'd8},  // R8 retained back, others zero
    '{1'b1, 2'd0, 8'h77, 1'b0, 1'b0, 1'b1, 32'h00330077, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 32'hFF00FF00, 1'b1, 1'b1, 4'd9},  // R9 off, no save
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 32'hFF00FF00, 1'b1, 1'b1, 4'd10}, // R10 save while off
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 32'hFF00FF00, 1'b1, 1'b1, 4'd7},  // R7 fall while off ignored
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 1'b1, 4'd5},  // R5 level restores at once
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 1'b1, 4'd10}, // R10 edge save while corrupt
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h00330011, 1'b0, 1'b0, 4'd11}  // R11 shadow kept 11, not 77
  };

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    ret_ctl = 1'b0; iso_en = 1'b0; pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "level data_out in reset", out_l, 32'h0);
    check("R1", "edge corrupt in reset", {31'd0, cor_e}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "level data_out after release", out_l, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].idx, VECS[i].dat, VECS[i].ret, VECS[i].iso,
           VECS[i].pg, VECS[i].exp, VECS[i].exp, VECS[i].cl, VECS[i].ce,
           $sformatf("R%0d", VECS[i].req));
    end

    // Write and save in one cycle: level keeps saving, edge captured the old value (R4, R6)
    step(1'b1, 2'd2, 8'hA5, 1'b1, 1'b0, 1'b1, 32'h00A50011, 32'h00A50011, 1'b0, 1'b0, "R6");
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 32'h00A50011, 32'h00A50011, 1'b0, 1'b0, "R4");
    // Edge restore without corruption (R7)
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h00A50011, 32'h00330011, 1'b0, 1'b0, "R7");
    // Power off with a write that must be dropped (R2, R9)
    step(1'b1, 2'd1, 8'h66, 1'b0, 1'b0, 1'b0, 32'h00A50011, 32'h00330011, 1'b1, 1'b1, "R2");
    // Level restores the continuously saved A5 (R4); edge still corrupt, r1 unchanged (R2)
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h00A50011, 32'h00330011, 1'b0, 1'b1, "R4");
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 32'h00A50011, 32'h00330011, 1'b0, 1'b1, "R10");
    // Restore beats a write in edge style; level has no restore due and takes the write (R8)
    step(1'b1, 2'd1, 8'h5A, 1'b0, 1'b0, 1'b1, 32'h00A55A11, 32'h00330011, 1'b0, 1'b0, "R8");

    // Asynchronous reset mid-run clears everything at once (R1)
    rst_n = 1'b0;
    #1;
    check("R1", "level data_out async clear", out_l, 32'h0);
    check("R1", "edge data_out async clear", out_e, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b0; ret_ctl = 1'b0; iso_en = 1'b0;
    repeat (3) @(negedge clk);
    // Shadows were cleared too: level restore after a power cycle yields zeros (R1, R5)
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, "R1");
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 1'b1, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule